// File: doc/BRIEF.md
# Interrupt State Vector Generator

This block sits beside a serial bus slave controller that runs in LIN mode and turns its interrupt events into one read-only vector byte. Each of six event sources has its own sticky pending flag. A fixed priority resolver picks the most important pending source. Its number is placed in the middle of the byte, so the value read is always a multiple of four and can be added straight to the base of a firmware jump table.

A single request line tells the processor that something is pending, gated by a global enable. Firmware reads the vector, jumps to the handler, and the handler clears its source with that source's clear strobe. The vector then moves to the next pending source, or to zero when nothing remains.

Top module: `isv_gen`

## Requirements
- R1: The vector byte keeps bits 7:6 and 1:0 at zero; the 4-bit source code occupies bits 5:2, so the byte equals code times four.
- R2: While reset is low and right after it, the vector reads 0x00 and the request line is low.
- R3: With no flag pending the code is 0, so the byte is 0x00.
- R4: Source input bit k (k = 0..5) maps to code k+1: bit 0 no-bus-activity (0x04), bit 1 transmit buffer empty after checksum sent (0x08), bit 2 transmit buffer empty (0x0C), bit 3 receive message complete with good checksum (0x10), bit 4 receive data byte ready without error (0x14), bit 5 bit error (0x18).
- R5: When several flags are pending, the vector shows the largest code among them.
- R6: A one-cycle event pulse on a source sets its pending flag, and the flag stays set through idle cycles until that source's clear strobe.
- R7: When an event pulse and a clear strobe hit the same source in the same cycle, the flag ends up set.
- R8: The request output is high exactly when at least one flag is pending and the enable input is high; it follows the flags in the same cycle they change.
- R9: The vector is registered: it shows the flags one clock after they change, so it lags the request line by one cycle.
- R10: Codes 7 to 15 never appear on the vector.
- R11: Clearing the highest pending source lets the vector fall to the next highest pending one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 6 | One-cycle event per source, bit k is code k+1 |
| clr_strobe | input | 6 | One-cycle clear per source, same bit order |
| irq_en | input | 1 | Global interrupt enable |
| vec_o | output | 8 | State vector byte, code in bits 5:2 |
| irq_o | output | 1 | Combined interrupt request |

## Verification
On every cycle the assertions check the byte layout and the absence of reserved codes, the gating of the request line, the set-over-clear rule, the removal of a cleared flag, and that the vector one cycle after an idle or bit-error state shows 0x00 or 0x18. The bench alone shows the full priority map: it sweeps all 64 pending combinations with the enable both high and low and compares against the highest set bit computed arithmetically. Its scenarios also show the one-cycle lag between request and vector, flags holding over idle cycles, and the step down to the next source after a clear.

// File: rtl/isv_pkg.sv
package isv_pkg;
  localparam int NUM_SRC = 6;
  localparam int CODE_W  = 4;
  localparam int VEC_W   = 8;
  localparam int CODE_LSB = 2;

  // Highest pending source wins; source k carries code k+1.
  function automatic logic [CODE_W-1:0] top_code(input logic [NUM_SRC-1:0] pend);
    logic [CODE_W-1:0] c;
    c = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend[i]) c = CODE_W'(i + 1);
    end
    return c;
  endfunction

  // Place the code in the middle of the byte, unused bits zero.
  function automatic logic [VEC_W-1:0] pack_vec(input logic [CODE_W-1:0] code);
    return VEC_W'(code) << CODE_LSB;
  endfunction
endpackage

// File: rtl/isv_flag_bank.sv
module isv_flag_bank #(
  parameter int NUM_SRC = isv_pkg::NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] pend
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (evt[g]) flag_q <= 1'b1;   // set beats clear
      else if (clr[g]) flag_q <= 1'b0;
    end
    assign pend[g] = flag_q;
  end
endmodule

// File: rtl/isv_prio_enc.sv
module isv_prio_enc
  import isv_pkg::*;
(
  input  logic [NUM_SRC-1:0] pend,
  output logic [CODE_W-1:0]  code
);
  always_comb code = top_code(pend);
endmodule

// File: rtl/isv_vec_reg.sv
module isv_vec_reg
  import isv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  output logic [VEC_W-1:0]  vec
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec <= '0;
    else        vec <= pack_vec(code);
  end
endmodule

// File: rtl/isv_gen.sv
module isv_gen
  import isv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_pulse,
  input  logic [NUM_SRC-1:0] clr_strobe,
  input  logic               irq_en,
  output logic [VEC_W-1:0]   vec_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] pend_q;
  logic [CODE_W-1:0]  win_code;
  logic               any_pend;

  isv_flag_bank #(.NUM_SRC(NUM_SRC)) flags_i (
    .clk(clk), .rst_n(rst_n), .evt(evt_pulse), .clr(clr_strobe), .pend(pend_q)
  );

  isv_prio_enc prio_i (.pend(pend_q), .code(win_code));

  isv_vec_reg vreg_i (.clk(clk), .rst_n(rst_n), .code(win_code), .vec(vec_o));

  assign any_pend = |pend_q;
  assign irq_o    = any_pend & irq_en;
endmodule

// File: rtl/isv_gen_chk.sv
module isv_gen_chk #(
  parameter int NUM_SRC = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] evt,
  input logic [NUM_SRC-1:0] clr,
  input logic               irq_en,
  input logic [NUM_SRC-1:0] pend,
  input logic [7:0]         vec,
  input logic               irq
);
  // R1: unused bits stay zero
  p_layout_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (vec[7:6] == 2'b00) && (vec[1:0] == 2'b00));

  // R2: in reset the vector is clear
  always @(posedge clk) begin
    if (!rst_n) p_reset_r2: assert (vec == 8'h00);
  end

  // R3: nothing pending yields zero on the next cycle
  p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |=> (vec == 8'h00));

  // R5: bit error outranks everything
  p_top_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend[NUM_SRC-1] |=> (vec == 8'(NUM_SRC << 2)));

  // R6: a clear without a set removes the flag
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(clr & ~evt)) == '0));

  // R7: event always leaves the flag set
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & $past(evt)) == $past(evt)));

  // R8: request only with enable and a pending flag
  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && (pend != '0)));

  // R10: reserved codes never seen
  p_no_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vec[5:2] <= 4'(NUM_SRC));
endmodule

bind isv_gen isv_gen_chk #(.NUM_SRC(isv_pkg::NUM_SRC)) chk_i (
  .clk(clk), .rst_n(rst_n), .evt(evt_pulse), .clr(clr_strobe),
  .irq_en(irq_en), .pend(pend_q), .vec(vec_o), .irq(irq_o)
);

// File: tb/isv_gen_tb.sv
module isv_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [5:0] evt = '0;
  logic [5:0] clr = '0;
  logic       en = 1'b0;
  logic [7:0] vec;
  logic       irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  isv_gen dut_i (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt), .clr_strobe(clr),
    .irq_en(en), .vec_o(vec), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Expected byte: (index of highest set bit + 1) * 4, from a logarithm.
  function automatic logic [7:0] exp_vec(input int p);
    if (p == 0) return 8'h00;
    return 8'($clog2(p + 1) * 4);
  endfunction

  task automatic step(input logic [5:0] e, input logic [5:0] c);
    evt = e; clr = c;
    @(negedge clk);
    evt = '0; clr = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    @(negedge clk);
    chk("R2 vec in reset", vec, 8'h00);
    chk("R2 irq in reset", {7'b0, irq}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    en = 1'b1;
    @(negedge clk);
    chk("R2 vec after reset", vec, 8'h00);
    chk("R3 idle", vec, 8'h00);

    // R4 R5 R8 R9 R1: all pending combinations, enable both ways
    for (int pass = 0; pass < 2; pass++) begin
      en = (pass == 0);
      for (int p = 0; p < 64; p++) begin
        step('0, 6'h3f);
        step(6'(p), '0);
        chk("R8 irq same cycle", {7'b0, irq}, {7'b0, (p != 0) && en});
        chk("R9 vector lags", vec, 8'h00);
        @(negedge clk);
        chk("R4 R5 R1 vector", vec, exp_vec(p));
      end
    end
    en = 1'b1;

    // R6: flag holds across idle cycles
    step('0, 6'h3f);
    step(6'b000100, '0);
    repeat (5) @(negedge clk);
    chk("R6 held", vec, 8'h0C);
    step('0, 6'b000100);
    @(negedge clk);
    chk("R6 cleared", vec, 8'h00);

    // R7: set and clear together
    step(6'b010000, 6'b010000);
    @(negedge clk);
    chk("R7 set wins", vec, 8'h14);
    chk("R7 irq", {7'b0, irq}, 8'h01);

    // R11: clear top, fall to next
    step('0, 6'h3f);
    step(6'b100001, '0);
    @(negedge clk);
    chk("R11 top first", vec, 8'h18);
    step('0, 6'b100000);
    chk("R11 irq kept", {7'b0, irq}, 8'h01);
    @(negedge clk);
    chk("R11 next source", vec, 8'h04);
    step('0, 6'b000001);
    chk("R8 irq drops", {7'b0, irq}, 8'h00);
    @(negedge clk);
    chk("R3 back to idle", vec, 8'h00);
    chk("R10 no reserved", {4'b0, vec[5:2]} > 8'd6 ? 8'h01 : 8'h00, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule